// File: doc/BRIEF.md
# BERT Receive Pattern Synchronizer

This block takes a received serial bit stream and checks it against a 2^15-1 pseudo-random reference (polynomial x^15 + x^14 + 1). A bit is accepted on any clock where the bit-enable input is high.

While searching, the block loads its local 15-bit generator straight from the received bits, so the generator seeds itself. It also counts how many of its predictions come true in a row. After 32 correct predictions in a row it declares lock.

Once locked, the generator runs freely. Every accepted bit is then counted, and every bit that differs from the prediction is counted as an error. Both counters stop at their maximum value instead of wrapping.

A sliding 64-bit error history drops lock as soon as it holds six or more errors. A separate run detector reports a stream of zeros whatever the lock state. A resync request forces a new search, and a clear strobe zeroes both counters.

Top module: `bert_rx_sync`

## Requirements
- R1: The sync flag rises only after 32 consecutive accepted bits have matched the local generator. It is never high fewer than 32 accepted bits after a search begins.
- R2: While locked, when the last 64 accepted bits contain 6 or more errors, the sync flag drops and the search pulse fires for one clock.
- R3: The bit counter and the error counter change only for bits accepted while locked. In search, both hold their values.
- R4: The error counter (ERR_W bits, default 24) counts up by one per errored bit and stops at its all-ones value. The error-saturation pulse fires once, on the bit that reaches that value.
- R5: The bit counter (BIT_W bits, default 32) counts up by one per accepted bit while locked and stops at its all-ones value. The bit-saturation pulse fires once, on reaching that value.
- R6: The clear strobe sets both counters to zero in one clock. Clear takes priority over counting. After a clear, each counter can saturate again and give a new saturation pulse.
- R7: The all-zeros flag goes high once 31 consecutive accepted bits have been zero. It goes low on the clock after an accepted one.
- R8: A resync request drops the sync flag on the next clock and fires the search pulse.
- R9: The error pulse fires for one clock for each errored bit accepted while locked, and never in search.
- R10: After reset, the sync flag, both counters, all pulses and the all-zeros flag are low or zero.
- R11: While locked, five errors inside one 64-bit span leave the lock in place. The error history is emptied when lock is acquired.
- R12: The generator prediction is the XOR of stages 15 and 14 of a 15-bit shift register. The predicted bit is shifted in at the low end, and in search the received bit is shifted in instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Accept `bit_in` on this clock |
| bit_in | input | 1 | Received serial data bit |
| cnt_clr | input | 1 | Zero both counters |
| resync | input | 1 | Force a new search |
| in_sync | output | 1 | Real-time lock status |
| err_cnt | output | ERR_W | Saturating errored-bit count |
| bit_cnt | output | BIT_W | Saturating received-bit count |
| err_pulse | output | 1 | One-clock pulse per detected bit error |
| search_pulse | output | 1 | One-clock pulse when a search starts |
| err_sat_pulse | output | 1 | One-clock pulse when the error counter saturates |
| bit_sat_pulse | output | 1 | One-clock pulse when the bit counter saturates |
| all_zeros | output | 1 | A run of 31 or more zeros is in progress |

## Verification
The assertions check these rules on every cycle:
- the counters never decrease except on a clear, and hold still during search;
- a clear or a resync takes effect on the next clock;
- error pulses appear only while locked, and saturation pulses never repeat back to back;
- the window count stays below the loss limit whenever lock is held;
- the zero flag rises only after an accepted zero.

Some behaviour needs long, chosen bit streams, so only the bench scenarios can show it:
- lock arriving no earlier than 32 bits into a search;
- exact counts after known runs;
- lock surviving five errors but falling at the sixth;
- saturation followed by re-arming after a clear;
- the exact length of the zero run.

// File: rtl/bert_rx_sync.sv
module bert_rx_sync #(
  parameter int PRBS_LEN  = 15,
  parameter int TAP_HI    = 15,
  parameter int TAP_LO    = 14,
  parameter int LOCK_RUN  = 32,
  parameter int WIN       = 64,
  parameter int ERR_LIMIT = 6,
  parameter int ZERO_RUN  = 31,
  parameter int ERR_W     = 24,
  parameter int BIT_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             cnt_clr,
  input  logic             resync,
  output logic             in_sync,
  output logic [ERR_W-1:0] err_cnt,
  output logic [BIT_W-1:0] bit_cnt,
  output logic             err_pulse,
  output logic             search_pulse,
  output logic             err_sat_pulse,
  output logic             bit_sat_pulse,
  output logic             all_zeros
);

  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam int WCW   = $clog2(WIN + 1);
  localparam int ZW    = $clog2(ZERO_RUN + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};
  localparam logic [BIT_W-1:0] BIT_MAX = {BIT_W{1'b1}};

  logic [PRBS_LEN-1:0] gen;
  logic [RUN_W-1:0]    run;
  logic [WIN-1:0]      hist;
  logic [WCW-1:0]      win_cnt;
  logic [ZW-1:0]       zrun;

  logic pred, mismatch, locked_bit, lock_hit, loss_hit;
  logic [WCW-1:0] win_nxt;

  assign pred       = gen[TAP_HI-1] ^ gen[TAP_LO-1];
  assign mismatch   = bit_in ^ pred;
  assign locked_bit = bit_en && in_sync && !resync;
  assign win_nxt    = win_cnt + WCW'(mismatch) - WCW'(hist[WIN-1]);
  assign lock_hit   = bit_en && !in_sync && !resync && !mismatch
                      && (run == RUN_W'(LOCK_RUN - 1));
  assign loss_hit   = locked_bit && (win_nxt >= WCW'(ERR_LIMIT));
  assign all_zeros  = (zrun == ZW'(ZERO_RUN));

  // Lock state machine, reference generator and loss window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_sync      <= 1'b0;
      gen          <= '0;
      run          <= '0;
      hist         <= '0;
      win_cnt      <= '0;
      search_pulse <= 1'b0;
      err_pulse    <= 1'b0;
    end else begin
      search_pulse <= 1'b0;
      err_pulse    <= 1'b0;
      if (resync) begin
        in_sync      <= 1'b0;
        run          <= '0;
        search_pulse <= 1'b1;
      end else if (bit_en && !in_sync) begin
        gen <= {gen[PRBS_LEN-2:0], bit_in};
        if (lock_hit) begin
          in_sync <= 1'b1;
          run     <= '0;
          hist    <= '0;
          win_cnt <= '0;
        end else begin
          run <= mismatch ? '0 : run + 1'b1;
        end
      end else if (locked_bit) begin
        gen       <= {gen[PRBS_LEN-2:0], pred};
        hist      <= {hist[WIN-2:0], mismatch};
        win_cnt   <= win_nxt;
        err_pulse <= mismatch;
        if (loss_hit) begin
          in_sync      <= 1'b0;
          run          <= '0;
          search_pulse <= 1'b1;
        end
      end
    end
  end

  // Saturating counters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_cnt       <= '0;
      bit_cnt       <= '0;
      err_sat_pulse <= 1'b0;
      bit_sat_pulse <= 1'b0;
    end else begin
      err_sat_pulse <= 1'b0;
      bit_sat_pulse <= 1'b0;
      if (cnt_clr) begin
        err_cnt <= '0;
        bit_cnt <= '0;
      end else if (locked_bit) begin
        if (bit_cnt != BIT_MAX) begin
          bit_cnt       <= bit_cnt + 1'b1;
          bit_sat_pulse <= (bit_cnt == BIT_MAX - 1'b1);
        end
        if (mismatch && err_cnt != ERR_MAX) begin
          err_cnt       <= err_cnt + 1'b1;
          err_sat_pulse <= (err_cnt == ERR_MAX - 1'b1);
        end
      end
    end
  end

  // Zero-run detector
  always_ff @(posedge clk) begin
    if (!rst_n) zrun <= '0;
    else if (bit_en) zrun <= bit_in ? '0 : (all_zeros ? zrun : zrun + 1'b1);
  end

  AST_LOCK_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> $past(bit_en) && !$past(resync)); // R1
  AST_WIN_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |-> win_cnt < WCW'(ERR_LIMIT)); // R2
  AST_NO_COUNT_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sync && !cnt_clr) |=> $stable(bit_cnt) && $stable(err_cnt)); // R3
  AST_ERR_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> err_cnt >= $past(err_cnt)); // R4
  AST_ESAT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    err_sat_pulse |=> !err_sat_pulse); // R4
  AST_BIT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> bit_cnt >= $past(bit_cnt)); // R5
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> err_cnt == '0 && bit_cnt == '0); // R6
  AST_ZERO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_zeros) |-> $past(bit_en) && !$past(bit_in)); // R7
  AST_RESYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !in_sync && search_pulse); // R8
  AST_ERR_PULSE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(in_sync)); // R9

endmodule

// File: tb/bert_rx_sync_tb_top.sv
module bert_rx_sync_tb_top;
  localparam int EW = 4;
  localparam int BW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 1'b0, bit_in = 1'b0, cnt_clr = 1'b0, resync = 1'b0;
  logic in_sync, err_pulse, search_pulse, err_sat_pulse, bit_sat_pulse, all_zeros;
  logic [EW-1:0] err_cnt;
  logic [BW-1:0] bit_cnt;

  int errors = 0, checks = 0;
  int n_err_p = 0, n_search_p = 0, n_esat_p = 0, n_bsat_p = 0;
  logic [14:0] g = 15'h1ACE;

  always #4 clk = ~clk;

  bert_rx_sync #(.ERR_W(EW), .BIT_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .cnt_clr(cnt_clr), .resync(resync), .in_sync(in_sync),
    .err_cnt(err_cnt), .bit_cnt(bit_cnt), .err_pulse(err_pulse),
    .search_pulse(search_pulse), .err_sat_pulse(err_sat_pulse),
    .bit_sat_pulse(bit_sat_pulse), .all_zeros(all_zeros));

  always @(posedge clk) begin
    #2;
    if (err_pulse)     n_err_p++;
    if (search_pulse)  n_search_p++;
    if (err_sat_pulse) n_esat_p++;
    if (bit_sat_pulse) n_bsat_p++;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_in = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_prbs(input int n, input logic flip);
    for (int i = 0; i < n; i++) begin
      logic nb;
      nb = g[14] ^ g[13];
      g = {g[13:0], nb};
      send_bit(nb ^ flip);
    end
  endtask

  task automatic pulse_clr();
    cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
  endtask

  task automatic pulse_resync();
    resync = 1'b1; @(negedge clk); resync = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 in_sync", in_sync, 0);
    chk("R10 err_cnt", err_cnt, 0);
    chk("R10 bit_cnt", bit_cnt, 0);
    chk("R10 pulses", {err_pulse, search_pulse, err_sat_pulse, bit_sat_pulse}, 0);
    chk("R10 all_zeros", all_zeros, 0);
  endtask

  task automatic t_lock();
    send_prbs(20, 1'b0);
    chk("R1 no lock before 32 bits", in_sync, 0);
    send_prbs(60, 1'b0);
    chk("R1 R12 locked on prbs", in_sync, 1);
  endtask

  task automatic t_count();
    pulse_clr();
    send_prbs(100, 1'b0);
    chk("R3 bit count", bit_cnt, 100);
    chk("R3 no errors on clean", err_cnt, 0);
    chk("R9 no err pulse clean", n_err_p, 0);
    send_prbs(1, 1'b1);
    chk("R9 single error counted", err_cnt, 1);
    chk("R9 err pulse", n_err_p, 1);
    chk("R9 still locked", in_sync, 1);
  endtask

  task automatic t_loss();
    int sp;
    pulse_clr();
    send_prbs(80, 1'b0);
    for (int i = 0; i < 5; i++) begin
      send_prbs(1, 1'b1);
      send_prbs(1, 1'b0);
    end
    chk("R11 five errors keep lock", in_sync, 1);
    sp = n_search_p;
    send_prbs(1, 1'b1);
    chk("R2 sixth error drops lock", in_sync, 0);
    chk("R2 search pulse", n_search_p, sp + 1);
    chk("R2 error count", err_cnt, 6);
    chk("R3 bits counted in lock", bit_cnt, 91);
    send_prbs(10, 1'b1);
    chk("R3 no errors in search", err_cnt, 6);
    chk("R3 no bits in search", bit_cnt, 91);
  endtask

  task automatic t_resync();
    int sp;
    send_prbs(60, 1'b0);
    chk("R1 relock", in_sync, 1);
    sp = n_search_p;
    pulse_resync();
    chk("R8 resync drops lock", in_sync, 0);
    chk("R8 resync pulse", n_search_p, sp + 1);
    send_prbs(60, 1'b0);
    chk("R1 relock after resync", in_sync, 1);
  endtask

  task automatic t_err_sat();
    pulse_clr();
    for (int i = 0; i < 15; i++) begin
      send_prbs(1, 1'b1);
      send_prbs(14, 1'b0);
    end
    chk("R4 error counter at max", err_cnt, 15);
    chk("R4 sat pulse once", n_esat_p, 1);
    chk("R11 spaced errors keep lock", in_sync, 1);
    send_prbs(1, 1'b1);
    send_prbs(14, 1'b0);
    chk("R4 error counter holds", err_cnt, 15);
    chk("R4 no second sat pulse", n_esat_p, 1);
  endtask

  task automatic t_bit_sat();
    pulse_clr();
    chk("R6 clear zeroes errors", err_cnt, 0);
    chk("R6 clear zeroes bits", bit_cnt, 0);
    send_prbs(260, 1'b0);
    chk("R5 bit counter at max", bit_cnt, 255);
    chk("R5 bit sat pulse once", n_bsat_p, 1);
    pulse_clr();
    send_prbs(255, 1'b0);
    chk("R6 re-saturate after clear", bit_cnt, 255);
    chk("R6 second sat pulse", n_bsat_p, 2);
  endtask

  task automatic t_zeros();
    pulse_resync();
    for (int i = 0; i < 30; i++) send_bit(1'b0);
    chk("R7 30 zeros not flagged", all_zeros, 0);
    send_bit(1'b0);
    chk("R7 31 zeros flagged", all_zeros, 1);
    send_bit(1'b0);
    chk("R7 flag held", all_zeros, 1);
    send_bit(1'b1);
    chk("R7 one clears flag", all_zeros, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_count();
    t_loss();
    t_resync();
    t_err_sat();
    t_bit_sat();
    t_zeros();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule